// File: doc/BRIEF.md
# Main-Board Control Port Decoder

This block sits on the main processor's I/O port bus. It decodes the low byte of each port address, acts on writes to a small set of control ports and answers reads from status ports. Writes set the memory-mapper selection fields and the RAM-disable flags. They also drive the companion processor's bus-request and reset lines, and the floppy drive-select, motor and terminal-count lines. Two interrupt enables live in the control bytes as well. Reads return stored control bytes, or status bytes built from live handshake inputs and configuration switch inputs.

The block holds a pending flag for the companion processor's interrupt. Any read or write access to the four-port acknowledge window clears that flag. The block combines the pending flag and the floppy interrupt line with their enables into one registered interrupt request. Working out the interrupt priority and modelling the floppy controller itself are left to other blocks.

Port accesses arrive as a valid/ready request stream. A request is taken on a clock edge where `io_req_valid` and `io_req_ready` are both high. Write effects appear in the cycle after that edge. A read produces one response beat, presented on `rd_valid`/`rd_data` in the cycle after acceptance. That beat is held unchanged until `rd_ready` is high at a clock edge. While a beat waits with `rd_ready` low, `io_req_ready` is low, so no new request of either kind is taken. When `rd_ready` is high, requests can be taken back to back.

Top module: `ctl_port_decoder`

## Requirements
- R1: Only `io_addr[7:0]` is decoded. A read of any port other than 0xFC–0xFF returns 0xFF, including the acknowledge window 0xEC–0xEF and ports 0xF8–0xFB. A write to a port outside 0xEC–0xEF and 0xF8, 0xFA, 0xFC–0xFF changes no output.
- R2: A read response stays valid with unchanged data while `rd_ready` is low, and `io_req_ready` is low during that time.
- R3: A write to 0xFC stores the whole byte, and a read of 0xFC returns it. `sub_busreq` follows stored bit 1. Stored bit 0 enables the companion interrupt.
- R4: A write to 0xFD stores the whole byte, and a read of 0xFD returns it. `map_mode` takes bits 1:0. `sub_reset` pulses high for exactly one cycle only when stored bit 7 goes from 0 to 1.
- R5: A write to 0xFE loads `opt_sel` from bits 2:0 and `upper_sel` from bits 7:4. A write to 0xFF loads `ram_dis_lo` from bit 0 and `ram_dis_hi` from bit 1. These fields change on no other access.
- R6: A write to 0xF8 or 0xFA with bit 6 set and any of bits 2:0 set pulses `drv_sel_valid` for one cycle, with `drv_num` equal to the index of the lowest set bit among bits 2:0. There is no pulse if bit 6 is clear or bits 2:0 are all zero.
- R7: A write to 0xF8 or 0xFA sets `fdc_motor` from bit 4, `fdc_tc` from bit 5, and the floppy interrupt enable from bit 7.
- R8: A read of 0xFE returns 0xE0 | ((~cfg_sw & 0x0B) << 1) | (mon_400line ? 0x00 : 0x08).
- R9: A read of 0xFF returns 0xC0 | (cfg_sw[7] ? 0x00 : 0x20) | (sub_rdy ? 0x10 : 0x00) | (sub_ack ? 0x00 : 0x08) | int_src.
- R10: A `sub_int_set` pulse sets the companion-interrupt pending flag. Any accepted read or write to 0xEC–0xEF clears it. If both happen in the same cycle, the set wins.
- R11: `irq` is the registered value of (pending AND companion enable) OR (`fdc_int` AND floppy enable). It changes one cycle after the pending flag, an enable or `fdc_int` changes.
- R12: After reset, every mapper field, stored byte, enable, pending flag and output is 0, and `io_req_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| io_req_valid | input | 1 | Port access request valid |
| io_req_ready | output | 1 | Request can be accepted |
| io_write | input | 1 | 1 = write, 0 = read |
| io_addr | input | 16 | Port address (low byte decoded) |
| io_wdata | input | 8 | Write data |
| rd_valid | output | 1 | Read response valid |
| rd_ready | input | 1 | Response consumer ready |
| rd_data | output | 8 | Read response data |
| sub_int_set | input | 1 | Companion interrupt event pulse |
| fdc_int | input | 1 | Floppy interrupt line |
| sub_rdy | input | 1 | Companion ready handshake |
| sub_ack | input | 1 | Companion acknowledge handshake |
| int_src | input | 3 | Interrupt source code for status |
| cfg_sw | input | 8 | Configuration switches |
| mon_400line | input | 1 | High-resolution monitor fitted |
| map_mode | output | 2 | Mapper mode |
| opt_sel | output | 3 | Option window select |
| upper_sel | output | 4 | Upper window select |
| ram_dis_lo | output | 1 | Lower middle RAM disable |
| ram_dis_hi | output | 1 | Upper middle RAM disable |
| sub_busreq | output | 1 | Companion bus request |
| sub_reset | output | 1 | Companion reset pulse |
| drv_sel_valid | output | 1 | Drive-select pulse |
| drv_num | output | 2 | Selected drive number |
| fdc_motor | output | 1 | Floppy motor |
| fdc_tc | output | 1 | Floppy terminal count |
| irq | output | 1 | Interrupt request |

## Verification
The bench writes bit 7 of the 0xFD port as 1 twice in a row. A design that treats reset as level-triggered would pulse `sub_reset` again on the second write. It sets several drive bits at once to find a design that picks the highest bit instead of the lowest. It also sends a drive-select write with bit 6 clear to find one that ignores the gate. The bench raises an interrupt event in the same cycle as an acknowledge-window write, which shows whether clear wrongly beats set. It reads the 0xFE and 0xFF status ports with switch patterns chosen so that a missing inversion, a wrong shift or a wrong mask changes the byte. Upper address bits are varied and a response is stalled, which shows a decoder that looks at the full address or a response that drops or changes while it waits.

// File: rtl/ctl_port_pkg.sv
package ctl_port_pkg;
  localparam int BYTE_W = 8;

  localparam logic [7:0] PORT_ACK_BASE = 8'hEC;
  localparam logic [7:0] PORT_FDC_A    = 8'hF8;
  localparam logic [7:0] PORT_FDC_B    = 8'hFA;
  localparam logic [7:0] PORT_SUBCTL   = 8'hFC;
  localparam logic [7:0] PORT_MAPMODE  = 8'hFD;
  localparam logic [7:0] PORT_WINSEL   = 8'hFE;
  localparam logic [7:0] PORT_RAMDIS   = 8'hFF;

  typedef struct packed {
    logic       ack_win;
    logic       fdc_ctl;
    logic       subctl;
    logic       mapmode;
    logic       winsel;
    logic       ramdis;
  } port_hit_t;

  function automatic port_hit_t decode_port(input logic [7:0] a);
    port_hit_t h;
    h.ack_win = (a[7:2] == PORT_ACK_BASE[7:2]);
    h.fdc_ctl = (a == PORT_FDC_A) || (a == PORT_FDC_B);
    h.subctl  = (a == PORT_SUBCTL);
    h.mapmode = (a == PORT_MAPMODE);
    h.winsel  = (a == PORT_WINSEL);
    h.ramdis  = (a == PORT_RAMDIS);
    return h;
  endfunction
endpackage

// File: rtl/ctl_wr_regs.sv
module ctl_wr_regs
  import ctl_port_pkg::*;
#(
  parameter int NUM_DRIVES = 3,
  localparam int DRV_W = (NUM_DRIVES > 1) ? $clog2(NUM_DRIVES) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  port_hit_t         hit,
  input  logic [BYTE_W-1:0] wdata,
  output logic [BYTE_W-1:0] subctl_q,
  output logic [BYTE_W-1:0] mapmode_q,
  output logic [2:0]        opt_sel,
  output logic [3:0]        upper_sel,
  output logic              ram_dis_lo,
  output logic              ram_dis_hi,
  output logic              sub_reset,
  output logic              drv_sel_valid,
  output logic [DRV_W-1:0]  drv_num,
  output logic              fdc_motor,
  output logic              fdc_tc,
  output logic              fdc_ie
);
  logic             drv_any;
  logic [DRV_W-1:0] drv_low;

  // lowest set drive bit wins: scan from the top so the last hit is lowest
  always_comb begin
    drv_any = 1'b0;
    drv_low = '0;
    for (int i = NUM_DRIVES - 1; i >= 0; i--) begin
      if (wdata[i]) begin
        drv_any = 1'b1;
        drv_low = DRV_W'(i);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      subctl_q      <= '0;
      mapmode_q     <= '0;
      opt_sel       <= '0;
      upper_sel     <= '0;
      ram_dis_lo    <= 1'b0;
      ram_dis_hi    <= 1'b0;
      sub_reset     <= 1'b0;
      drv_sel_valid <= 1'b0;
      drv_num       <= '0;
      fdc_motor     <= 1'b0;
      fdc_tc        <= 1'b0;
      fdc_ie        <= 1'b0;
    end else begin
      sub_reset     <= 1'b0;
      drv_sel_valid <= 1'b0;
      if (wr_en) begin
        if (hit.subctl) subctl_q <= wdata;
        if (hit.mapmode) begin
          sub_reset <= wdata[7] && !mapmode_q[7];
          mapmode_q <= wdata;
        end
        if (hit.winsel) begin
          opt_sel   <= wdata[2:0];
          upper_sel <= wdata[7:4];
        end
        if (hit.ramdis) begin
          ram_dis_lo <= wdata[0];
          ram_dis_hi <= wdata[1];
        end
        if (hit.fdc_ctl) begin
          fdc_motor <= wdata[4];
          fdc_tc    <= wdata[5];
          fdc_ie    <= wdata[7];
          if (wdata[6] && drv_any) begin
            drv_sel_valid <= 1'b1;
            drv_num       <= drv_low;
          end
        end
      end
    end
  end
endmodule

// File: rtl/ctl_rd_mux.sv
module ctl_rd_mux
  import ctl_port_pkg::*;
(
  input  port_hit_t         hit,
  input  logic [BYTE_W-1:0] subctl_q,
  input  logic [BYTE_W-1:0] mapmode_q,
  input  logic [BYTE_W-1:0] cfg_sw,
  input  logic              mon_400line,
  input  logic              sub_rdy,
  input  logic              sub_ack,
  input  logic [2:0]        int_src,
  output logic [BYTE_W-1:0] rdata
);
  logic [BYTE_W-1:0] winsel_stat;
  logic [BYTE_W-1:0] ramdis_stat;
  logic [BYTE_W-1:0] sw_inv_sel;

  assign sw_inv_sel  = ~cfg_sw & 8'h0B;
  assign winsel_stat = 8'hE0 | {sw_inv_sel[6:0], 1'b0} | (mon_400line ? 8'h00 : 8'h08);
  assign ramdis_stat = 8'hC0 | (cfg_sw[7] ? 8'h00 : 8'h20) | (sub_rdy ? 8'h10 : 8'h00)
                     | (sub_ack ? 8'h00 : 8'h08) | {5'b0, int_src};

  always_comb begin
    rdata = 8'hFF;
    if (hit.subctl)       rdata = subctl_q;
    else if (hit.mapmode) rdata = mapmode_q;
    else if (hit.winsel)  rdata = winsel_stat;
    else if (hit.ramdis)  rdata = ramdis_stat;
  end
endmodule

// File: rtl/ctl_irq.sv
module ctl_irq #(
  parameter int NSRC = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            latch_set,
  input  logic            latch_clr,
  input  logic [NSRC-2:0] level_src,
  input  logic [NSRC-1:0] src_en,
  output logic            irq
);
  logic            pend_q;
  logic [NSRC-1:0] active;

  always_ff @(posedge clk) begin
    if (!rst_n)         pend_q <= 1'b0;
    else if (latch_set) pend_q <= 1'b1;
    else if (latch_clr) pend_q <= 1'b0;
  end

  assign active[0] = pend_q & src_en[0];
  for (genvar g = 1; g < NSRC; g++) begin : g_lvl
    assign active[g] = level_src[g-1] & src_en[g];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) irq <= 1'b0;
    else        irq <= |active;
  end
endmodule

// File: rtl/ctl_port_decoder.sv
module ctl_port_decoder
  import ctl_port_pkg::*;
#(
  parameter int ADDR_W     = 16,
  parameter int NUM_DRIVES = 3,
  localparam int DRV_W = (NUM_DRIVES > 1) ? $clog2(NUM_DRIVES) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              io_req_valid,
  output logic              io_req_ready,
  input  logic              io_write,
  input  logic [ADDR_W-1:0] io_addr,
  input  logic [BYTE_W-1:0] io_wdata,
  output logic              rd_valid,
  input  logic              rd_ready,
  output logic [BYTE_W-1:0] rd_data,
  input  logic              sub_int_set,
  input  logic              fdc_int,
  input  logic              sub_rdy,
  input  logic              sub_ack,
  input  logic [2:0]        int_src,
  input  logic [BYTE_W-1:0] cfg_sw,
  input  logic              mon_400line,
  output logic [1:0]        map_mode,
  output logic [2:0]        opt_sel,
  output logic [3:0]        upper_sel,
  output logic              ram_dis_lo,
  output logic              ram_dis_hi,
  output logic              sub_busreq,
  output logic              sub_reset,
  output logic              drv_sel_valid,
  output logic [DRV_W-1:0]  drv_num,
  output logic              fdc_motor,
  output logic              fdc_tc,
  output logic              irq
);
  port_hit_t         hit;
  logic              accept;
  logic [BYTE_W-1:0] subctl_q;
  logic [BYTE_W-1:0] mapmode_q;
  logic [BYTE_W-1:0] rd_next;
  logic              fdc_ie;

  assign hit          = decode_port(io_addr[7:0]);
  assign io_req_ready = !rd_valid || rd_ready;
  assign accept       = io_req_valid && io_req_ready;

  ctl_wr_regs #(.NUM_DRIVES(NUM_DRIVES)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(accept && io_write), .hit(hit), .wdata(io_wdata),
    .subctl_q(subctl_q), .mapmode_q(mapmode_q), .opt_sel(opt_sel), .upper_sel(upper_sel),
    .ram_dis_lo(ram_dis_lo), .ram_dis_hi(ram_dis_hi), .sub_reset(sub_reset),
    .drv_sel_valid(drv_sel_valid), .drv_num(drv_num), .fdc_motor(fdc_motor),
    .fdc_tc(fdc_tc), .fdc_ie(fdc_ie)
  );

  ctl_rd_mux u_rd (
    .hit(hit), .subctl_q(subctl_q), .mapmode_q(mapmode_q), .cfg_sw(cfg_sw),
    .mon_400line(mon_400line), .sub_rdy(sub_rdy), .sub_ack(sub_ack),
    .int_src(int_src), .rdata(rd_next)
  );

  ctl_irq #(.NSRC(2)) u_irq (
    .clk(clk), .rst_n(rst_n), .latch_set(sub_int_set),
    .latch_clr(accept && hit.ack_win), .level_src(fdc_int),
    .src_en({fdc_ie, subctl_q[0]}), .irq(irq)
  );

  assign map_mode   = mapmode_q[1:0];
  assign sub_busreq = subctl_q[1];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else if (accept && !io_write) begin
      rd_valid <= 1'b1;
      rd_data  <= rd_next;
    end else if (rd_ready) begin
      rd_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/ctl_port_chk.sv
module ctl_port_chk #(
  parameter int ADDR_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              io_req_valid,
  input logic              io_req_ready,
  input logic              io_write,
  input logic [ADDR_W-1:0] io_addr,
  input logic [7:0]        io_wdata,
  input logic              rd_valid,
  input logic              rd_ready,
  input logic [7:0]        rd_data,
  input logic              sub_reset,
  input logic              drv_sel_valid,
  input logic [1:0]        map_mode,
  input logic [2:0]        opt_sel,
  input logic [3:0]        upper_sel,
  input logic              ram_dis_lo,
  input logic              ram_dis_hi
);
  logic acc_wr;
  assign acc_wr = io_req_valid && io_req_ready && io_write;

  AST_RST_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    sub_reset |=> !sub_reset); // R4
  AST_RST_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    sub_reset |-> $past(acc_wr && io_addr[7:0] == 8'hFD && io_wdata[7])); // R4
  AST_DRV_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    drv_sel_valid |-> $past(acc_wr && (io_addr[7:0] == 8'hF8 || io_addr[7:0] == 8'hFA)
                            && io_wdata[6])); // R6
  AST_RSP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && !rd_ready) |=> (rd_valid && $stable(rd_data))); // R2
  AST_REQ_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && !rd_ready) |-> !io_req_ready); // R2
  AST_MAP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_wr |=> $stable({map_mode, opt_sel, upper_sel, ram_dis_lo, ram_dis_hi})); // R5
endmodule

bind ctl_port_decoder ctl_port_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .io_req_valid(io_req_valid), .io_req_ready(io_req_ready),
  .io_write(io_write), .io_addr(io_addr), .io_wdata(io_wdata), .rd_valid(rd_valid),
  .rd_ready(rd_ready), .rd_data(rd_data), .sub_reset(sub_reset),
  .drv_sel_valid(drv_sel_valid), .map_mode(map_mode), .opt_sel(opt_sel),
  .upper_sel(upper_sel), .ram_dis_lo(ram_dis_lo), .ram_dis_hi(ram_dis_hi)
);

// File: tb/tb_ctl_port_decoder.sv
module tb_ctl_port_decoder;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic io_req_valid = 1'b0, io_write = 1'b0, rd_ready = 1'b1;
  logic [15:0] io_addr = '0;
  logic [7:0]  io_wdata = '0, cfg_sw = '0;
  logic sub_int_set = 1'b0, fdc_int = 1'b0, sub_rdy = 1'b0, sub_ack = 1'b0, mon_400line = 1'b0;
  logic [2:0] int_src = '0;
  logic io_req_ready, rd_valid, ram_dis_lo, ram_dis_hi, sub_busreq, sub_reset;
  logic drv_sel_valid, fdc_motor, fdc_tc, irq;
  logic [7:0] rd_data;
  logic [1:0] map_mode, drv_num;
  logic [2:0] opt_sel;
  logic [3:0] upper_sel;

  int checks = 0, errors = 0, cycles = 0;
  bit done = 1'b0;
  logic [7:0] exp_q[$];
  string      tag_q[$];

  always #2.5 clk = ~clk;

  ctl_port_decoder dut (
    .clk(clk), .rst_n(rst_n), .io_req_valid(io_req_valid), .io_req_ready(io_req_ready),
    .io_write(io_write), .io_addr(io_addr), .io_wdata(io_wdata), .rd_valid(rd_valid),
    .rd_ready(rd_ready), .rd_data(rd_data), .sub_int_set(sub_int_set), .fdc_int(fdc_int),
    .sub_rdy(sub_rdy), .sub_ack(sub_ack), .int_src(int_src), .cfg_sw(cfg_sw),
    .mon_400line(mon_400line), .map_mode(map_mode), .opt_sel(opt_sel),
    .upper_sel(upper_sel), .ram_dis_lo(ram_dis_lo), .ram_dis_hi(ram_dis_hi),
    .sub_busreq(sub_busreq), .sub_reset(sub_reset), .drv_sel_valid(drv_sel_valid),
    .drv_num(drv_num), .fdc_motor(fdc_motor), .fdc_tc(fdc_tc), .irq(irq)
  );

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // caller is at a negedge; returns at the negedge after the accepting edge
  task automatic acc(input bit w, input logic [15:0] a, input logic [7:0] d);
    io_req_valid = 1'b1; io_write = w; io_addr = a; io_wdata = d;
    while (!io_req_ready) @(negedge clk);
    @(negedge clk);
    io_req_valid = 1'b0;
  endtask

  task automatic wr(input logic [15:0] a, input logic [7:0] d);
    acc(1'b1, a, d);
  endtask

  task automatic rd(input logic [15:0] a, input logic [7:0] exp, input string tag);
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    acc(1'b0, a, 8'h00);
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && rd_valid && rd_ready) begin
      if (exp_q.size() == 0) begin
        checks++; errors++;
        $display("FAIL R2 unexpected response actual=%0h expected=none", rd_data);
      end else begin
        chk(tag_q.pop_front(), {8'h0, rd_data}, {8'h0, exp_q.pop_front()});
      end
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000 && !done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=%0d expected=<20000", cycles);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  function automatic logic [7:0] exp_fe(input logic [7:0] sw, input logic m4);
    return 8'hE0 | ((~sw & 8'h0B) << 1) | (m4 ? 8'h00 : 8'h08);
  endfunction

  function automatic logic [7:0] exp_ff(input logic [7:0] sw, input logic r, input logic a,
                                         input logic [2:0] s);
    return 8'hC0 | (sw[7] ? 8'h00 : 8'h20) | (r ? 8'h10 : 8'h00) | (a ? 8'h00 : 8'h08) | s;
  endfunction

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R12 reset state
    chk("R12 map_mode", map_mode, 0);
    chk("R12 busreq/irq/motor", {sub_busreq, irq, fdc_motor, ram_dis_lo}, 0);
    chk("R12 ready", io_req_ready, 1);
    rd(16'h00FD, 8'h00, "R12 FD reset value");

    // R5 field writes, upper address bits ignored (R1)
    wr(16'h55FE, 8'hA5);
    chk("R5 opt_sel", opt_sel, 3'd5);
    chk("R5 upper_sel", upper_sel, 4'hA);
    wr(16'h00FF, 8'h03);
    chk("R5 ram_dis", {ram_dis_hi, ram_dis_lo}, 2'b11);
    wr(16'h00F0, 8'hFF);
    chk("R1 unhandled write", {opt_sel, upper_sel, ram_dis_hi, ram_dis_lo, map_mode}, {3'd5, 4'hA, 2'b11, 2'b00});
    rd(16'h00F0, 8'hFF, "R1 unhandled read");
    rd(16'hABF9, 8'hFF, "R1 read F9");

    // R4 reset pulse on rising bit 7 only
    wr(16'h00FD, 8'h81);
    chk("R4 reset pulse", sub_reset, 1);
    chk("R4 map_mode", map_mode, 1);
    @(negedge clk);
    chk("R4 pulse one cycle", sub_reset, 0);
    wr(16'h00FD, 8'h82);
    chk("R4 no pulse when bit7 stays", sub_reset, 0);
    chk("R4 map_mode 2", map_mode, 2);
    rd(16'h12FD, 8'h82, "R4 FD readback");
    wr(16'h00FD, 8'h03);
    wr(16'h00FD, 8'h80);
    chk("R4 pulse after re-arm", sub_reset, 1);

    // R3
    wr(16'h00FC, 8'h5A);
    chk("R3 busreq", sub_busreq, 1);
    rd(16'h00FC, 8'h5A, "R3 FC readback");
    wr(16'h00FC, 8'h00);
    chk("R3 busreq off", sub_busreq, 0);

    // R6 / R7
    wr(16'h00F8, 8'h44);
    chk("R6 drv pulse", {drv_sel_valid, drv_num}, {1'b1, 2'd2});
    wr(16'h00FA, 8'h47);
    chk("R6 lowest bit", {drv_sel_valid, drv_num}, {1'b1, 2'd0});
    wr(16'h00F8, 8'h07);
    chk("R6 gate bit6 clear", drv_sel_valid, 0);
    wr(16'h00F8, 8'h40);
    chk("R6 no drive bits", drv_sel_valid, 0);
    wr(16'h00FA, 8'h30);
    chk("R7 motor tc", {fdc_motor, fdc_tc}, 2'b11);
    wr(16'h00FA, 8'h10);
    chk("R7 tc off", {fdc_motor, fdc_tc}, 2'b10);

    // R8 / R9
    cfg_sw = 8'h00; mon_400line = 1'b1;
    rd(16'h00FE, exp_fe(8'h00, 1'b1), "R8 FE sw=00");
    cfg_sw = 8'h02; mon_400line = 1'b0;
    rd(16'h00FE, exp_fe(8'h02, 1'b0), "R8 FE sw=02");
    cfg_sw = 8'hFF;
    rd(16'h00FE, exp_fe(8'hFF, 1'b0), "R8 FE sw=FF");
    cfg_sw = 8'h00; sub_rdy = 1'b1; sub_ack = 1'b0; int_src = 3'd5;
    rd(16'h00FF, exp_ff(8'h00, 1'b1, 1'b0, 3'd5), "R9 FF pattern A");
    cfg_sw = 8'h80; sub_rdy = 1'b0; sub_ack = 1'b1; int_src = 3'd2;
    rd(16'h00FF, exp_ff(8'h80, 1'b0, 1'b1, 3'd2), "R9 FF pattern B");

    // R2 stalled response
    @(posedge clk); #1 rd_ready = 1'b0;
    @(negedge clk);
    exp_q.push_back(8'h5A ^ 8'h5A); tag_q.push_back("R2 stalled FC read");
    acc(1'b0, 16'h00FC, 8'h00);
    repeat (3) @(negedge clk);
    chk("R2 held valid", rd_valid, 1);
    chk("R2 ready low", io_req_ready, 0);
    @(posedge clk); #1 rd_ready = 1'b1;
    @(negedge clk);

    // R10 / R11
    wr(16'h00FC, 8'h01);
    sub_int_set = 1'b1; @(negedge clk); sub_int_set = 1'b0;
    chk("R11 irq latency", irq, 0);
    @(negedge clk);
    chk("R11 irq set", irq, 1);
    rd(16'h00EC, 8'hFF, "R1 ack window read");
    chk("R11 irq before clear seen", irq, 1);
    @(negedge clk);
    chk("R10 read clears", irq, 0);
    sub_int_set = 1'b1;
    wr(16'h00EF, 8'h00);
    sub_int_set = 1'b0;
    @(negedge clk);
    chk("R10 set wins", irq, 1);
    wr(16'h00ED, 8'h00);
    @(negedge clk);
    chk("R10 write clears", irq, 0);
    wr(16'h00F8, 8'h80);
    fdc_int = 1'b1;
    @(negedge clk); @(negedge clk);
    chk("R11 fdc irq", irq, 1);
    wr(16'h00F8, 8'h00);
    @(negedge clk);
    chk("R11 fdc enable off", irq, 0);
    fdc_int = 1'b0;

    repeat (4) @(negedge clk);
    chk("R2 scoreboard drained", exp_q.size(), 0);
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule